// File: doc/BRIEF.md
# Adaptive Decay Mode Controller

This block chooses how the winding current of one H-bridge decays during each PWM off-time in a current-chopping stepper driver. At every PWM cycle boundary it looks back at the cycle that just ended and adjusts a fast-decay level. It checks whether the current went past the trip level and whether the drive phase took longer than a programmable number of clocks to reach the trip level. It also looks at whether the present microstep is falling. From the level it gives a decay command: slow, mixed with a 4-bit fast-decay fraction in sixteenths of the off-time, or full fast.

The adaptive scheme applies only when an enable input is high and every fixed decay-select input is low. That choice is captured on the first clock after reset and on each exit from sleep. It is not captured at any other time. Each capture also moves the level back to the middle of its range. Analog sensing, gate drive, the sine DAC and step indexing are outside the block.

Top module: `adapt_decay_ctrl`

## Requirements
- R1: `auto_active` is set by a capture event when `auto_en` is 1 and `fixed_sel` is all zero, and cleared by a capture event otherwise. Capture events are the first rising clock edge after `rst_n` goes high and the first rising clock edge at which `awake` is seen high after being low.
- R2: Changes of `auto_en` or `fixed_sel` between capture events leave `auto_active` and the decay outputs unchanged.
- R3: A capture event that sets `auto_active` puts the level at its midpoint, so the outputs read mixed decay with fraction 8.
- R4: `decay_mode` uses the encoding 0 = slow, 1 = mixed, 2 = fast, and never reads 3. The outputs change only on the clock edge where `cyc_start` is 1, or on a capture event. The update uses the overshoot and drive-time observations collected since the previous `cyc_start`.
- R5: When an overshoot pulse was seen in the ended cycle, the level rises by one.
- R6: When no overshoot was seen and the ended cycle's count of `drive_on` clocks exceeds `long_thr`, the level drops by one. A count equal to `long_thr` leaves the level unchanged.
- R7: When overshoot and a long drive time occur in the same cycle, the level rises.
- R8: Level 0 reads slow decay with fraction 0, and a further decrease keeps it there. Levels 1 to 15 read mixed decay with the fraction equal to the level. A rise from 15 reads fast decay with fraction 15, and a further rise stays fast.
- R9: When `step_fall` is 1 at `cyc_start`, the outputs read fast decay with fraction 15, and the level is held unchanged.
- R10: The first update after a falling step where `step_fall` is 0 restores the held level and discards that cycle's feedback. Tuning resumes at the following update.
- R11: While `auto_active` is 0, the outputs read slow decay with fraction 0, and PWM-cycle feedback has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| awake | input | 1 | High when not in sleep; a low-to-high change triggers a capture |
| auto_en | input | 1 | Request for adaptive decay |
| fixed_sel | input | DSEL_W | Fixed decay-select inputs; must be all zero for adaptive mode |
| cyc_start | input | 1 | One-clock pulse at each PWM cycle boundary |
| drive_on | input | 1 | High during the drive phase of the PWM cycle |
| overshoot | input | 1 | Pulse when the winding current goes past the trip level |
| step_fall | input | 1 | High when the current microstep is falling, sampled at `cyc_start` |
| long_thr | input | CNT_W | Drive-phase clock count above which drive time is long |
| auto_active | output | 1 | Captured adaptive-mode enable |
| decay_mode | output | 2 | Decay command: 0 slow, 1 mixed, 2 fast |
| fast_frac | output | FRAC_W | Fast-decay fraction in sixteenths |

## Verification
The hardest states to reach are the two ends of the level range and the return from a falling step. Getting there takes long runs of PWM cycles with the same kind of feedback, and the held level has to survive several fast-decay cycles. The bench sets a known level from the vector table, then repeats long-drive cycles until the level reaches the floor and overshoot cycles until it goes past the top. It then places falling steps at the top and checks the restored level. Capture behaviour is reached by toggling `awake` with `auto_en` and `fixed_sel` in different settings, and by changing them while the controller stays awake.

// File: rtl/adc_pkg.sv
package adc_pkg;
   typedef enum logic [1:0] {
      DCY_SLOW  = 2'd0,
      DCY_MIXED = 2'd1,
      DCY_FAST  = 2'd2
   } decay_e;
endpackage

// File: rtl/adc_enable_latch.sv
module adc_enable_latch #(
   parameter int DSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              awake,
   input  logic              auto_en,
   input  logic [DSEL_W-1:0] fixed_sel,
   output logic              lat_evt,
   output logic              active
);
   logic boot_q;
   logic awake_q;

   // capture on first edge after reset and on every wake-up
   assign lat_evt = boot_q | (awake & ~awake_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q  <= 1'b1;
         awake_q <= 1'b0;
         active  <= 1'b0;
      end else begin
         boot_q  <= 1'b0;
         awake_q <= awake;
         if (lat_evt)
            active <= auto_en & ~(|fixed_sel);
      end
   end
endmodule

// File: rtl/adc_cycle_obs.sv
module adc_cycle_obs #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_start,
   input  logic             drive_on,
   input  logic             overshoot,
   input  logic [CNT_W-1:0] long_thr,
   output logic             ovs_seen,
   output logic             drive_long
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             ovs_q;
   logic             step_en;

   generate
      if (SATURATE) begin : g_sat
         assign step_en = drive_on && (cnt_q != CNT_MAX);
      end else begin : g_wrap
         assign step_en = drive_on;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovs_q <= 1'b0;
      end else if (cyc_start) begin
         cnt_q <= {{(CNT_W-1){1'b0}}, drive_on};
         ovs_q <= overshoot;
      end else begin
         if (step_en)
            cnt_q <= cnt_q + 1'b1;
         if (overshoot)
            ovs_q <= 1'b1;
      end
   end

   assign ovs_seen   = ovs_q;
   assign drive_long = (cnt_q > long_thr);
endmodule

// File: rtl/adc_level_tuner.sv
module adc_level_tuner #(
   parameter int FRAC_W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lat_evt,
   input  logic          active,
   input  logic          cyc_start,
   input  logic          step_fall,
   input  logic          ovs_seen,
   input  logic          drive_long,
   output logic [FRAC_W:0] level,
   output logic          fall_hold
);
   localparam int              LVL_W = FRAC_W + 1;
   localparam logic [LVL_W-1:0] TOP  = LVL_W'(1 << FRAC_W);
   localparam logic [LVL_W-1:0] MID  = LVL_W'(1 << (FRAC_W - 1));

   logic [LVL_W-1:0] lvl_q;
   logic [LVL_W-1:0] lvl_nx;
   logic             fall_q;

   always_comb begin
      lvl_nx = lvl_q;
      if (ovs_seen) begin
         if (lvl_q != TOP) lvl_nx = lvl_q + 1'b1;
      end else if (drive_long) begin
         if (lvl_q != '0) lvl_nx = lvl_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= MID;
         fall_q <= 1'b0;
      end else if (lat_evt) begin
         lvl_q  <= MID;
         fall_q <= 1'b0;
      end else if (cyc_start && active) begin
         if (step_fall)
            fall_q <= 1'b1;
         else if (fall_q)
            fall_q <= 1'b0;
         else
            lvl_q <= lvl_nx;
      end
   end

   assign level     = lvl_q;
   assign fall_hold = fall_q;
endmodule

// File: rtl/adapt_decay_ctrl.sv
module adapt_decay_ctrl #(
   parameter int DSEL_W   = 2,
   parameter int CNT_W    = 8,
   parameter int FRAC_W   = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              awake,
   input  logic              auto_en,
   input  logic [DSEL_W-1:0] fixed_sel,
   input  logic              cyc_start,
   input  logic              drive_on,
   input  logic              overshoot,
   input  logic              step_fall,
   input  logic [CNT_W-1:0]  long_thr,
   output logic              auto_active,
   output logic [1:0]        decay_mode,
   output logic [FRAC_W-1:0] fast_frac
);
   import adc_pkg::*;

   localparam int               LVL_W = FRAC_W + 1;
   localparam logic [LVL_W-1:0] TOP   = LVL_W'(1 << FRAC_W);

   generate
      if (FRAC_W < 2 || FRAC_W > 8) begin : g_bad_frac
         $error("FRAC_W must lie in 2..8");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (DSEL_W < 1) begin : g_bad_dsel
         $error("DSEL_W must be at least 1");
      end
   endgenerate

   logic             lat_evt;
   logic             ovs_seen;
   logic             drive_long;
   logic [LVL_W-1:0] level;
   logic             fall_hold;
   decay_e           mode_w;

   adc_enable_latch #(.DSEL_W(DSEL_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .awake(awake), .auto_en(auto_en),
      .fixed_sel(fixed_sel), .lat_evt(lat_evt), .active(auto_active)
   );

   adc_cycle_obs #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_obs (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .drive_on(drive_on),
      .overshoot(overshoot), .long_thr(long_thr),
      .ovs_seen(ovs_seen), .drive_long(drive_long)
   );

   adc_level_tuner #(.FRAC_W(FRAC_W)) u_tune (
      .clk(clk), .rst_n(rst_n), .lat_evt(lat_evt), .active(auto_active),
      .cyc_start(cyc_start), .step_fall(step_fall), .ovs_seen(ovs_seen),
      .drive_long(drive_long), .level(level), .fall_hold(fall_hold)
   );

   always_comb begin
      mode_w    = DCY_SLOW;
      fast_frac = '0;
      if (auto_active) begin
         if (fall_hold || level == TOP) begin
            mode_w    = DCY_FAST;
            fast_frac = '1;
         end else if (level != '0) begin
            mode_w    = DCY_MIXED;
            fast_frac = level[FRAC_W-1:0];
         end
      end
   end

   assign decay_mode = mode_w;
endmodule

// File: rtl/adapt_decay_chk.sv
module adapt_decay_chk #(
   parameter int FRAC_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_start,
   input logic              step_fall,
   input logic              lat_evt,
   input logic              auto_active,
   input logic [1:0]        decay_mode,
   input logic [FRAC_W-1:0] fast_frac
);
   // R1
   active_only_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(auto_active) |-> $past(lat_evt));

   // R4
   frac_change_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fast_frac) |-> ($past(cyc_start) || $past(lat_evt)));

   // R4
   mode_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decay_mode != 2'd3);

   // R9
   fall_forces_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && step_fall && auto_active && !lat_evt) |=> (decay_mode == 2'd2));

   // R11
   idle_reads_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_active |-> (decay_mode == 2'd0 && fast_frac == '0));

   // R8
   slow_has_zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decay_mode == 2'd0) |-> (fast_frac == '0));
endmodule

bind adapt_decay_ctrl adapt_decay_chk #(.FRAC_W(FRAC_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .step_fall(step_fall),
   .lat_evt(lat_evt), .auto_active(auto_active), .decay_mode(decay_mode),
   .fast_frac(fast_frac)
);

// File: tb/adapt_decay_ctrl_tb.sv
module adapt_decay_ctrl_tb_top;
   localparam int CLK_PER = 10;
   localparam int NVEC    = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       awake = 1'b1;
   logic       auto_en = 1'b1;
   logic [1:0] fixed_sel = 2'b00;
   logic       cyc_start = 1'b0;
   logic       drive_on = 1'b0;
   logic       overshoot = 1'b0;
   logic       step_fall = 1'b0;
   logic [7:0] long_thr = 8'd10;
   logic       auto_active;
   logic [1:0] decay_mode;
   logic [3:0] fast_frac;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   adapt_decay_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .awake(awake), .auto_en(auto_en),
      .fixed_sel(fixed_sel), .cyc_start(cyc_start), .drive_on(drive_on),
      .overshoot(overshoot), .step_fall(step_fall), .long_thr(long_thr),
      .auto_active(auto_active), .decay_mode(decay_mode), .fast_frac(fast_frac)
   );

   always #(CLK_PER/2) clk = ~clk;

   // {ovs, fall, drive clocks[7:0], mode[1:0], frac[3:0]}
   localparam logic [15:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 8'd4,  2'd1, 4'd8},   // R4 no feedback: hold
      {1'b1, 1'b0, 8'd4,  2'd1, 4'd9},   // R5 overshoot raises
      {1'b0, 1'b0, 8'd15, 2'd1, 4'd8},   // R6 long drive lowers
      {1'b1, 1'b0, 8'd15, 2'd1, 4'd9},   // R7 both: raise
      {1'b0, 1'b0, 8'd10, 2'd1, 4'd9},   // R6 equal to threshold: hold
      {1'b0, 1'b0, 8'd11, 2'd1, 4'd8},   // R6 one above: lower
      {1'b0, 1'b1, 8'd4,  2'd2, 4'd15},  // R9 falling: fast
      {1'b1, 1'b1, 8'd4,  2'd2, 4'd15},  // R9 still falling, level held
      {1'b1, 1'b0, 8'd4,  2'd1, 4'd8},   // R10 restore, feedback dropped
      {1'b1, 1'b0, 8'd4,  2'd1, 4'd9}    // R10 tuning resumes
   };

   task automatic chk(input string req, input logic ea, input logic [1:0] em,
                      input logic [3:0] ef);
      total++;
      if (auto_active !== ea || decay_mode !== em || fast_frac !== ef) begin
         bad++;
         $display("FAIL %s: active=%0b mode=%0d frac=%0d expected active=%0b mode=%0d frac=%0d",
                  req, auto_active, decay_mode, fast_frac, ea, em, ef);
      end
   endtask

   // one PWM cycle, ends just after the cyc_start edge
   task automatic pwm(input logic ovs, input int n, input logic fall);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         drive_on = 1'b1;
      end
      @(negedge clk);
      drive_on  = 1'b0;
      overshoot = ovs;
      @(negedge clk);
      overshoot = 1'b0;
      @(negedge clk);
      cyc_start = 1'b1;
      step_fall = fall;
      @(negedge clk);
      cyc_start = 1'b0;
      step_fall = 1'b0;
   endtask

   task automatic wake(input logic en, input logic [1:0] fs);
      @(negedge clk);
      awake = 1'b0;
      @(negedge clk);
      @(negedge clk);
      auto_en   = en;
      fixed_sel = fs;
      awake     = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PER * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset", 1'b0, 2'd0, 4'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 R3 boot capture", 1'b1, 2'd1, 4'd8);

      for (int v = 0; v < NVEC; v++) begin
         pwm(VEC[v][15], int'(VEC[v][13:6]), VEC[v][14]);
         chk($sformatf("vector %0d", v), 1'b1, VEC[v][5:4], VEC[v][3:0]);
      end

      // R8 floor: level 9 down to 0, then one more
      for (int i = 0; i < 9; i++) pwm(1'b0, 15, 1'b0);
      chk("R8 floor reached", 1'b1, 2'd0, 4'd0);
      pwm(1'b0, 15, 1'b0);
      chk("R8 floor holds", 1'b1, 2'd0, 4'd0);

      // R8 top
      for (int i = 0; i < 15; i++) pwm(1'b1, 4, 1'b0);
      chk("R8 mixed 15", 1'b1, 2'd1, 4'd15);
      pwm(1'b1, 4, 1'b0);
      chk("R8 above top is fast", 1'b1, 2'd2, 4'd15);
      pwm(1'b1, 4, 1'b0);
      chk("R8 fast holds", 1'b1, 2'd2, 4'd15);
      pwm(1'b0, 15, 1'b0);
      chk("R8 back to mixed 15", 1'b1, 2'd1, 4'd15);

      // R10 falling step at level 15, long drive on return is discarded
      pwm(1'b0, 4, 1'b1);
      chk("R9 fall at 15", 1'b1, 2'd2, 4'd15);
      pwm(1'b0, 15, 1'b0);
      chk("R10 restore 15", 1'b1, 2'd1, 4'd15);

      // R2 changes while awake ignored
      @(negedge clk);
      auto_en   = 1'b0;
      fixed_sel = 2'b11;
      repeat (3) @(negedge clk);
      chk("R2 ignored change", 1'b1, 2'd1, 4'd15);

      // R1 wake with enable low
      wake(1'b0, 2'b00);
      chk("R1 wake disabled", 1'b0, 2'd0, 4'd0);
      pwm(1'b1, 4, 1'b0);
      chk("R11 feedback no effect", 1'b0, 2'd0, 4'd0);

      // R1 wake with a fixed select set
      wake(1'b1, 2'b01);
      chk("R1 wake fixed select", 1'b0, 2'd0, 4'd0);

      // R3 wake enabled: level back to midpoint
      wake(1'b1, 2'b00);
      chk("R3 wake midpoint", 1'b1, 2'd1, 4'd8);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule